// File: doc/BRIEF.md
# Three-Phase Gate Sequencer with Dead-Time Interlock

This block sits between a motor controller and the six gate drivers of a three-phase half-bridge. Each phase has two command bits, one asking for its upper switch and one for its lower switch. Two shared active-low chopping inputs can remap these commands. `pwmh` low moves each upper request to the lower switch of the same phase. `pwml` low moves each lower request to the upper switch. With both low, every phase has its drive polarity reversed. The remapped requests pass through a per-phase interlock and a registered output stage, which gives six gate enables.

Each phase has its own dead-time down-counter. The counter loads a window whenever either output of that phase falls. While the counter is nonzero, the complementary switch may not turn on. A switch whose complement went off long ago turns on after the single output register, with no added delay.

A two-bit mode selects where the window comes from: the `dt_count` input, a fixed default set by a parameter, or zero for an external controller that handles timing itself. The upper and lower switch of a phase may overlap only when the mode is the external one and `xcond_en` is high. Two inputs force all six outputs off: the active-low `coast_n` and the `fault_off` input from the protection logic.

Top module: `tri_gate_sequencer`

## Requirements
- R1: While `rst_n` is low, all six outputs are low at every clock edge, and every dead-time counter is cleared.
- R2: With `pwmh`=0 and `pwml`=1, a phase with its upper command set has its upper output off and its lower output on. Lower commands pass unchanged.
- R3: With `pwml`=0 and `pwmh`=1, a phase with its lower command set has its lower output off and its upper output on. Upper commands pass unchanged.
- R4: With `pwmh`=0 and `pwml`=0, each phase's upper output follows its lower command and its lower output follows its upper command.
- R5: A clock edge that samples `coast_n`=0 leaves all six outputs low, whatever the other inputs are.
- R6: A clock edge that samples `fault_off`=1 leaves all six outputs low, whatever the other inputs are.
- R7: If a phase requests both of its switches (after remapping) and overlap is not allowed, both outputs of that phase stay off.
- R8: Both outputs of one phase may be high together only when the previous edge sampled `dt_mode`=2'b10 with `xcond_en`=1. In every other case the interlock prevents overlap.
- R9: When an output falls at edge E, its complement on the same phase cannot rise before edge E+N+1. N is `dt_count` for `dt_mode`=2'b00, the parameter DT_DEFAULT for 2'b01 and 2'b11, and 0 for 2'b10. A complement held requested throughout rises at exactly E+N+1.
- R10: A request for a switch whose complement is off and whose phase counter has expired is honoured at the first clock edge.
- R11: With `dt_mode`=2'b10 and `xcond_en`=1, a swap of commands within one phase takes effect on both outputs at the same edge. A request for both switches turns both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd | input | NPH | Per-phase upper switch command |
| lo_cmd | input | NPH | Per-phase lower switch command |
| pwmh | input | 1 | Active-low upper chop: moves upper requests to lower |
| pwml | input | 1 | Active-low lower chop: moves lower requests to upper |
| coast_n | input | 1 | Active-low forced all-off |
| fault_off | input | 1 | Protection disable, forces all-off while high |
| dt_mode | input | 2 | 00 counted, 01/11 default, 10 external (zero) |
| dt_count | input | DT_W | Dead-time window for counted mode, in cycles |
| xcond_en | input | 1 | Permits overlap in external mode; tie low when unused |
| gate_hi | output | NPH | Upper gate enables |
| gate_lo | output | NPH | Lower gate enables |

## Verification
The bench sweeps all 64 command combinations of the three phases under each of the four chopping settings, and compares the settled outputs with the remap. Running every chop setting separates the upper-to-lower move, the lower-to-upper move and the full polarity swap. The same sweep exposes the conflict rule when remapping lands both requests on one phase. Single-phase swaps measure the off-to-on gap in each window mode, including the reserved code and the overlap case. A late request after the window has expired shows that no delay is added when the complement has been off long enough. A per-cycle monitor watches for overlap of any phase outside the overlap mode.

// File: rtl/gatesq_pkg.sv
package gatesq_pkg;
   typedef enum logic [1:0] {
      DT_COUNTED  = 2'b00,
      DT_FIXED    = 2'b01,
      DT_EXTERNAL = 2'b10,
      DT_RESERVED = 2'b11
   } dt_mode_e;
endpackage

// File: rtl/gatesq_remap.sv
// Applies the shared chopping controls to the per-phase commands.
module gatesq_remap #(
   parameter int NPH = 3
) (
   input  logic [NPH-1:0] hi_cmd,
   input  logic [NPH-1:0] lo_cmd,
   input  logic           pwmh,
   input  logic           pwml,
   output logic [NPH-1:0] req_hi,
   output logic [NPH-1:0] req_lo
);
   logic [NPH-1:0] keep_hi, keep_lo;

   always_comb begin
      keep_hi = {NPH{pwmh}};
      keep_lo = {NPH{pwml}};
      // a chopped side hands its request to the opposite switch
      req_hi  = (hi_cmd & keep_hi) | (lo_cmd & ~keep_lo);
      req_lo  = (lo_cmd & keep_lo) | (hi_cmd & ~keep_hi);
   end
endmodule

// File: rtl/gatesq_window.sv
// Selects the dead-time window length and the overlap permission.
module gatesq_window
   import gatesq_pkg::*;
#(
   parameter int DT_W       = 6,
   parameter int DT_DEFAULT = 63
) (
   input  logic [1:0]      dt_mode,
   input  logic [DT_W-1:0] dt_count,
   input  logic            xcond_en,
   output logic [DT_W-1:0] win,
   output logic            ovl_ok
);
   localparam logic [DT_W-1:0] FIXED_WIN = DT_W'(DT_DEFAULT);

   dt_mode_e mode;

   always_comb begin
      mode   = dt_mode_e'(dt_mode);
      ovl_ok = 1'b0;
      unique case (mode)
         DT_COUNTED:  win = dt_count;
         DT_EXTERNAL: begin
            win    = '0;
            ovl_ok = xcond_en;
         end
         default:     win = FIXED_WIN;
      endcase
   end
endmodule

// File: rtl/gatesq_leg.sv
// One phase: interlock, registered gate enables, dead-time down-counter.
module gatesq_leg #(
   parameter int DT_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_hi,
   input  logic            req_lo,
   input  logic            kill,
   input  logic            ovl_ok,
   input  logic [DT_W-1:0] win,
   output logic            gate_hi,
   output logic            gate_lo
);
   logic [DT_W-1:0] cnt;
   logic            conflict, quiet, hi_nx, lo_nx, fall;

   always_comb begin
      conflict = req_hi & req_lo & ~ovl_ok;
      quiet    = (cnt == '0);
      // an output already on may stay on; turning on needs a quiet complement
      hi_nx    = req_hi & ~kill & ~conflict & (gate_hi | ovl_ok | (~gate_lo & quiet));
      lo_nx    = req_lo & ~kill & ~conflict & (gate_lo | ovl_ok | (~gate_hi & quiet));
      fall     = (gate_hi & ~hi_nx) | (gate_lo & ~lo_nx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
         cnt     <= '0;
      end else begin
         gate_hi <= hi_nx;
         gate_lo <= lo_nx;
         if (fall)
            cnt <= win;
         else if (!quiet)
            cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/tri_gate_sequencer.sv
module tri_gate_sequencer #(
   parameter int NPH        = 3,
   parameter int DT_W       = 6,
   parameter int DT_DEFAULT = (1 << DT_W) - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPH-1:0]  hi_cmd,
   input  logic [NPH-1:0]  lo_cmd,
   input  logic            pwmh,
   input  logic            pwml,
   input  logic            coast_n,
   input  logic            fault_off,
   input  logic [1:0]      dt_mode,
   input  logic [DT_W-1:0] dt_count,
   input  logic            xcond_en,
   output logic [NPH-1:0]  gate_hi,
   output logic [NPH-1:0]  gate_lo
);
   localparam int DT_LIMIT = (1 << DT_W) - 1;

   if (NPH < 1) begin : g_bad_nph
      $error("NPH must be at least 1");
   end
   if (DT_W < 1 || DT_W > 16) begin : g_bad_w
      $error("DT_W out of range 1..16");
   end
   if (DT_DEFAULT < 0 || DT_DEFAULT > DT_LIMIT) begin : g_bad_def
      $error("DT_DEFAULT does not fit in DT_W bits");
   end

   logic [NPH-1:0]  req_hi, req_lo;
   logic [DT_W-1:0] win;
   logic            ovl_ok, kill;

   assign kill = ~coast_n | fault_off;

   gatesq_remap #(.NPH(NPH)) u_remap (
      .hi_cmd (hi_cmd),
      .lo_cmd (lo_cmd),
      .pwmh   (pwmh),
      .pwml   (pwml),
      .req_hi (req_hi),
      .req_lo (req_lo)
   );

   gatesq_window #(.DT_W(DT_W), .DT_DEFAULT(DT_DEFAULT)) u_window (
      .dt_mode  (dt_mode),
      .dt_count (dt_count),
      .xcond_en (xcond_en),
      .win      (win),
      .ovl_ok   (ovl_ok)
   );

   for (genvar p = 0; p < NPH; p++) begin : g_leg
      gatesq_leg #(.DT_W(DT_W)) u_leg (
         .clk     (clk),
         .rst_n   (rst_n),
         .req_hi  (req_hi[p]),
         .req_lo  (req_lo[p]),
         .kill    (kill),
         .ovl_ok  (ovl_ok),
         .win     (win),
         .gate_hi (gate_hi[p]),
         .gate_lo (gate_lo[p])
      );
   end
endmodule

// File: rtl/tri_gate_sequencer_chk.sv
module tri_gate_sequencer_chk #(
   parameter int NPH = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           coast_n,
   input logic           fault_off,
   input logic [1:0]     dt_mode,
   input logic           xcond_en,
   input logic [NPH-1:0] gate_hi,
   input logic [NPH-1:0] gate_lo
);
   logic ovl_in;
   assign ovl_in = (dt_mode == 2'b10) && xcond_en;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (gate_hi == '0 && gate_lo == '0));

   // R5
   coast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !coast_n |=> (gate_hi == '0 && gate_lo == '0));

   // R6
   fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off |=> (gate_hi == '0 && gate_lo == '0));

   // R8
   interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_hi & gate_lo) != '0) |-> $past(ovl_in));

   // R9
   no_early_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ovl_in) |-> ((gate_hi & ~$past(gate_hi) & $past(gate_lo)) == '0
                      && (gate_lo & ~$past(gate_lo) & $past(gate_hi)) == '0));
endmodule

bind tri_gate_sequencer tri_gate_sequencer_chk #(.NPH(NPH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .coast_n   (coast_n),
   .fault_off (fault_off),
   .dt_mode   (dt_mode),
   .xcond_en  (xcond_en),
   .gate_hi   (gate_hi),
   .gate_lo   (gate_lo)
);

// File: tb/test_tri_gate_sequencer.sv
module test_tri_gate_sequencer;
   localparam int NPH = 3;
   localparam int DT_W = 6;
   localparam int DEF = 63;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NPH-1:0] hi_cmd = '0, lo_cmd = '0;
   logic           pwmh = 1'b1, pwml = 1'b1, coast_n = 1'b1, fault_off = 1'b0;
   logic [1:0]     dt_mode = 2'b00;
   logic [DT_W-1:0] dt_count = 6'd3;
   logic           xcond_en = 1'b0;
   logic [NPH-1:0] gate_hi, gate_lo;

   int errors = 0, checks = 0, viol = 0;
   logic mon_en = 1'b0;

   always #2 clk = ~clk;

   tri_gate_sequencer #(.NPH(NPH), .DT_W(DT_W)) i_tri_gate_sequencer (
      .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
      .pwmh(pwmh), .pwml(pwml), .coast_n(coast_n), .fault_off(fault_off),
      .dt_mode(dt_mode), .dt_count(dt_count), .xcond_en(xcond_en),
      .gate_hi(gate_hi), .gate_lo(gate_lo));

   // R8 monitor: overlap is never legal while it is armed
   always @(negedge clk)
      if (mon_en && (gate_hi & gate_lo) != '0) viol++;

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // swap phase 0 from lower to upper and measure the gap
   task automatic gap_test(input int exp_gap, input string tag);
      int klo, khi;
      @(negedge clk);
      hi_cmd = 3'b000; lo_cmd = 3'b001;
      idle(80);
      hi_cmd = 3'b001; lo_cmd = 3'b000;
      klo = -1; khi = -1;
      for (int k = 1; k <= 100; k++) begin
         @(negedge clk);
         if (klo < 0 && !gate_lo[0]) klo = k;
         if (khi < 0 && gate_hi[0]) khi = k;
      end
      check(klo, 1, tag);
      check(khi - klo, exp_gap, tag);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // R1: reset holds outputs low even with commands present
      @(negedge clk);
      hi_cmd = 3'b111;
      idle(4);
      check({gate_hi, gate_lo}, 0, "R1");
      hi_cmd = '0;
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      check({gate_hi, gate_lo}, 0, "R1");

      // remap sweep, counted window of 3
      mon_en = 1'b1;
      for (int c = 0; c < 256; c++) begin
         logic [2:0] h, l, rh, rl, cf;
         logic ph, pl;
         string tag;
         h = c[2:0]; l = c[5:3]; ph = c[6]; pl = c[7];
         hi_cmd = h; lo_cmd = l; pwmh = ph; pwml = pl;
         idle(12);
         rh = (h & {3{ph}}) | (l & {3{~pl}});
         rl = (l & {3{pl}}) | (h & {3{~ph}});
         cf = rh & rl;
         if (!ph && !pl) tag = "R4";
         else if (!ph) tag = "R2";
         else if (!pl) tag = "R3";
         else tag = "R7";
         check({gate_hi, gate_lo}, {rh & ~cf, rl & ~cf}, tag);
      end
      pwmh = 1'b1; pwml = 1'b1;

      // R9: gap per window source
      dt_mode = 2'b00; dt_count = 6'd0; gap_test(1, "R9 counted0");
      dt_count = 6'd1;                 gap_test(2, "R9 counted1");
      dt_count = 6'd5;                 gap_test(6, "R9 counted5");
      dt_mode = 2'b01;                 gap_test(DEF + 1, "R9 default");
      dt_mode = 2'b11;                 gap_test(DEF + 1, "R9 reserved");
      dt_mode = 2'b10;                 gap_test(1, "R9 external");

      // R10: late requests after window expiry pass straight through
      dt_mode = 2'b00; dt_count = 6'd5;
      hi_cmd = '0; lo_cmd = '0;
      idle(20);
      hi_cmd = 3'b010;
      @(negedge clk);
      check(gate_hi, 3'b010, "R10 rise");
      hi_cmd = '0;
      idle(10);
      lo_cmd = 3'b010;
      @(negedge clk);
      check(gate_lo, 3'b010, "R10 late complement");
      lo_cmd = '0;
      idle(10);

      // R5: coast forces all off and holds through command changes
      hi_cmd = 3'b101; lo_cmd = 3'b010;
      idle(10);
      check({gate_hi, gate_lo}, {3'b101, 3'b010}, "R5 before");
      coast_n = 1'b0;
      @(negedge clk);
      check({gate_hi, gate_lo}, 0, "R5");
      hi_cmd = 3'b010; lo_cmd = 3'b101;
      idle(3);
      check({gate_hi, gate_lo}, 0, "R5 hold");
      coast_n = 1'b1;
      idle(10);
      check({gate_hi, gate_lo}, {3'b010, 3'b101}, "R5 release");

      // R6: fault disable
      fault_off = 1'b1;
      @(negedge clk);
      check({gate_hi, gate_lo}, 0, "R6");
      idle(3);
      check({gate_hi, gate_lo}, 0, "R6 hold");
      fault_off = 1'b0;
      idle(10);
      check({gate_hi, gate_lo}, {3'b010, 3'b101}, "R6 release");

      // R7: both requested without overlap permission
      dt_mode = 2'b10; xcond_en = 1'b0;
      hi_cmd = 3'b100; lo_cmd = 3'b100;
      idle(10);
      check({gate_hi, gate_lo}, 0, "R7 external no enable");

      // R11: overlap permitted
      mon_en = 1'b0;
      hi_cmd = '0; lo_cmd = '0;
      idle(4);
      xcond_en = 1'b1;
      hi_cmd = 3'b100; lo_cmd = 3'b100;
      @(negedge clk);
      check({gate_hi, gate_lo}, {3'b100, 3'b100}, "R11 both");
      gap_test(0, "R11 swap");
      xcond_en = 1'b0;
      hi_cmd = '0; lo_cmd = '0;
      idle(4);

      check(viol, 0, "R8 overlap count");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule